// File: doc/BRIEF.md
# Buffered Serial Byte Transmitter with Status Flags

This block sends bytes as asynchronous serial frames. A bus write places a byte in a one-entry holding register. The next bit-rate strobe moves the byte into a shift register, and the shift register then sends a start bit (0), eight data bits with the least significant bit first, an optional parity bit, and a stop bit (1). If another byte is already waiting when the stop bit ends, the next frame starts at once with no idle bit. When there is nothing to send, the line rests at mark (1).

Alongside the data line the block drives a companion shift clock in SPI mode 3 style. The clock is low for the first half of each data bit and high for the second half. It stays high during idle, start, parity and stop bits. The half-bit point is given by a mid-bit strobe that comes from the same external rate generator as the bit strobe.

Two status flags can be read at any time:

- **Buffer-empty** shows that the holding register can take a byte.
- **Done** shows that the line has gone quiet after a stop bit.

The interrupt follows either buffer-empty or done, depending on a select input.

Top module: `sertx_buffered`

## Requirements
- R1: After reset with `en` high, `txd` = 1, `sclk` = 1, `stat_o` = 2'b01 (bit 0 = buffer-empty, bit 1 = done) and `irq` = 0.
- R2: A frame is a start bit of 0, then data bits 0 to 7 in that order, then a stop bit of 1. `txd` changes only on the clock edge that consumes a `bit_tick` pulse.
- R3: When `par_en` is high at load time, a parity bit follows data bit 7. It is the XOR of the eight data bits, inverted when `par_odd` is 1.
- R4: From idle with a byte buffered, the first `bit_tick` loads the shifter while `txd` stays 1. The start bit appears on the following `bit_tick`.
- R5: If a byte is buffered when the stop bit ends, the `bit_tick` that ends the stop bit also loads that byte and drives the start bit.
- R6: Buffer-empty (`stat_o[0]`) is 1 while enabled. A write clears it on the next edge, and it is set again by the `bit_tick` that moves the byte into the shifter.
- R7: Done (`stat_o[1]`) is set by the `bit_tick` that ends a stop bit with no byte pending. It is cleared only by a `stat_rd` pulse.
- R8: `sclk` is 0 only during data bits: it goes low on the edge that starts a data bit and high on the edge that consumes `mid_tick`.
- R9: With `irq_done_sel` = 0, `irq` equals buffer-empty, but only after a byte has been loaded into the shifter since enable. `irq` stays 0 straight after enable.
- R10: With `irq_done_sel` = 1, `irq` follows the done flag.
- R11: With `en` low, the shifter is cleared, `txd` and `sclk` are 1, both flags and the interrupt-armed state are cleared, and writes are ignored.
- R12: A write while a byte is already buffered replaces that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low clears all state |
| bit_tick | input | 1 | One-cycle strobe at the bit rate |
| mid_tick | input | 1 | One-cycle strobe at the middle of each bit period |
| par_en | input | 1 | Adds a parity bit to frames |
| par_odd | input | 1 | Selects odd parity (1) or even parity (0) |
| irq_done_sel | input | 1 | Interrupt source: 0 = buffer-empty, 1 = done |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| stat_rd | input | 1 | Status read strobe; clears the done flag |
| stat_o | output | 2 | {done, buffer-empty} |
| txd | output | 1 | Serial data output |
| sclk | output | 1 | Companion shift clock |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks the exact bit position of the first start bit after a write from idle. A design that skipped the load bit would send its start bit one bit early, and one that idled after every frame would leave a gap that the back-to-back test catches. The bench also checks that `irq` stays low after enable even though buffer-empty is set, and again after disabling and re-enabling the block; a design that drove the interrupt straight from the flag would fire at once. Further tests cover a second write that replaces a waiting byte, parity values for both even and odd settings, the done flag staying set until a read, and `sclk` staying high outside the data bits.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_START = 3'd2,
    ST_DATA  = 3'd3,
    ST_PAR   = 3'd4,
    ST_STOP  = 3'd5
  } tx_state_e;
endpackage

// File: rtl/sertx_hold.sv
// One-entry holding register ahead of the shifter.
module sertx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);
  logic          full_q, full_d;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (take) full_d = 1'b0;
    if (wr_en) begin
      full_d = 1'b1;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (!en) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;
endmodule

// File: rtl/sertx_shift.sv
// Frame sequencer: shifter, parity, serial line and companion clock.
module sertx_shift import sertx_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          bit_tick,
  input  logic          mid_tick,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          buf_full,
  input  logic [DW-1:0] buf_data,
  output logic          take,
  output logic          done,
  output logic          txd,
  output logic          sclk,
  output tx_state_e     state
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  tx_state_e     st_q, st_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          par_q, par_d, pen_q, pen_d;
  logic          txd_q, txd_d, sclk_q, sclk_d;

  assign take = en & bit_tick & buf_full & ((st_q == ST_IDLE) | (st_q == ST_STOP));
  assign done = en & bit_tick & ~buf_full & (st_q == ST_STOP);

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    par_d  = par_q;
    pen_d  = pen_q;
    txd_d  = txd_q;
    sclk_d = sclk_q;
    if (bit_tick) begin
      unique case (st_q)
        ST_IDLE:  if (buf_full) st_d = ST_LOAD;
        ST_LOAD:  begin st_d = ST_START; txd_d = 1'b0; end
        ST_START: begin
          st_d  = ST_DATA;
          txd_d = sh_q[0];
          sh_d  = sh_q >> 1;
          cnt_d = '0;
        end
        ST_DATA: begin
          if (cnt_q == LAST) begin
            if (pen_q) begin st_d = ST_PAR;  txd_d = par_q; end
            else       begin st_d = ST_STOP; txd_d = 1'b1;  end
          end else begin
            txd_d = sh_q[0];
            sh_d  = sh_q >> 1;
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PAR:   begin st_d = ST_STOP; txd_d = 1'b1; end
        ST_STOP: begin
          if (buf_full) begin st_d = ST_START; txd_d = 1'b0; end
          else          begin st_d = ST_IDLE;  txd_d = 1'b1; end
        end
        default:  begin st_d = ST_IDLE; txd_d = 1'b1; end
      endcase
      if (take) begin
        sh_d  = buf_data;
        par_d = (^buf_data) ^ par_odd;
        pen_d = par_en;
      end
      sclk_d = (st_d != ST_DATA);
    end else if (mid_tick) begin
      sclk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      par_q  <= 1'b0;
      pen_q  <= 1'b0;
      txd_q  <= 1'b1;
      sclk_q <= 1'b1;
    end else if (!en) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      par_q  <= 1'b0;
      pen_q  <= 1'b0;
      txd_q  <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      par_q  <= par_d;
      pen_q  <= pen_d;
      txd_q  <= txd_d;
      sclk_q <= sclk_d;
    end
  end

  assign txd   = txd_q;
  assign sclk  = sclk_q;
  assign state = st_q;
endmodule

// File: rtl/sertx_status.sv
// Status flags and interrupt selection.
module sertx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       buf_full,
  input  logic       take,
  input  logic       done,
  input  logic       stat_rd,
  input  logic       irq_done_sel,
  output logic [1:0] stat_o,
  output logic       irq
);
  logic cmp_q, cmp_d, arm_q, arm_d, empty;

  always_comb begin
    cmp_d = cmp_q;
    arm_d = arm_q;
    if (stat_rd) cmp_d = 1'b0;
    if (done)    cmp_d = 1'b1;
    if (take)    arm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (!en) begin
      cmp_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      arm_q <= arm_d;
    end
  end

  assign empty  = en & ~buf_full;
  assign stat_o = {cmp_q, empty};
  assign irq    = irq_done_sel ? cmp_q : (arm_q & empty);
endmodule

// File: rtl/sertx_buffered.sv
module sertx_buffered import sertx_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          bit_tick,
  input  logic          mid_tick,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          irq_done_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          stat_rd,
  output logic [1:0]    stat_o,
  output logic          txd,
  output logic          sclk,
  output logic          irq
);
  logic          buf_full, take, done;
  logic [DW-1:0] buf_data;
  tx_state_e     fsm_state;

  sertx_hold #(.DW(DW)) hold_i (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .full(buf_full), .data(buf_data)
  );

  sertx_shift #(.DW(DW)) shift_i (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_tick(bit_tick), .mid_tick(mid_tick),
    .par_en(par_en), .par_odd(par_odd), .buf_full(buf_full), .buf_data(buf_data),
    .take(take), .done(done), .txd(txd), .sclk(sclk), .state(fsm_state)
  );

  sertx_status status_i (
    .clk(clk), .rst_n(rst_n), .en(en), .buf_full(buf_full), .take(take),
    .done(done), .stat_rd(stat_rd), .irq_done_sel(irq_done_sel),
    .stat_o(stat_o), .irq(irq)
  );
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker import sertx_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       bit_tick,
  input logic       wr_en,
  input logic       stat_rd,
  input logic       irq_done_sel,
  input logic [1:0] stat_o,
  input logic       txd,
  input logic       sclk,
  input logic       irq,
  input tx_state_e  state
);
  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bit_tick) |=> $stable(txd)); // R2
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en) |=> !stat_o[0]); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stat_o[1] && !stat_rd) |=> stat_o[1]); // R7
  AST_SCLK_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> (state == ST_DATA)); // R8
  AST_NO_IRQ_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && !irq_done_sel) |-> !irq); // R9
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (txd && sclk && !stat_o[1])); // R11
endmodule

bind sertx_buffered sertx_checker chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .bit_tick(bit_tick), .wr_en(wr_en),
  .stat_rd(stat_rd), .irq_done_sel(irq_done_sel), .stat_o(stat_o),
  .txd(txd), .sclk(sclk), .irq(irq), .state(fsm_state)
);

// File: tb/sertx_buffered_tb_top.sv
`timescale 1ns/1ps
module sertx_buffered_tb_top;
  logic       clk, rst_n, en, bit_tick, mid_tick, par_en, par_odd, irq_done_sel;
  logic       wr_en, stat_rd, tick_on;
  logic [7:0] wr_data;
  logic [1:0] stat_o;
  logic       txd, sclk, irq;
  int         n_chk, n_bad, tcnt;
  bit         ended;

  sertx_buffered dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_tick(bit_tick), .mid_tick(mid_tick),
    .par_en(par_en), .par_odd(par_odd), .irq_done_sel(irq_done_sel),
    .wr_en(wr_en), .wr_data(wr_data), .stat_rd(stat_rd),
    .stat_o(stat_o), .txd(txd), .sclk(sclk), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Rate strobes: bit strobe every 8 cycles, mid strobe 4 cycles after it.
  initial begin
    tcnt = 0; bit_tick = 1'b0; mid_tick = 1'b0;
    forever begin
      @(posedge clk);
      tcnt     <= (tcnt == 7) ? 0 : tcnt + 1;
      bit_tick <= tick_on && (tcnt == 7);
      mid_tick <= tick_on && (tcnt == 3);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Wait until a bit strobe has been consumed, then sample.
  task automatic step();
    do @(negedge clk); while (!bit_tick);
    @(negedge clk);
  endtask

  task automatic sync_tick();
    step();
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_status();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  // After the start bit: data bits, optional parity, stop bit.
  task automatic bits(input logic [7:0] d, input logic pe, input logic po);
    for (int i = 0; i < 8; i++) begin
      step();
      chk("R2 data bit", txd, d[i]);
      if (i == 0) begin
        chk("R8 sclk low early in data bit", sclk, 1'b0);
        repeat (5) @(negedge clk);
        chk("R8 sclk high after mid", sclk, 1'b1);
      end
    end
    if (pe) begin
      step();
      chk("R3 parity bit", txd, (^d) ^ po);
      chk("R8 sclk high in parity", sclk, 1'b1);
    end
    step();
    chk("R2 stop bit", txd, 1'b1);
    chk("R8 sclk high in stop", sclk, 1'b1);
  endtask

  task automatic frame_from_idle(input logic [7:0] d, input logic pe, input logic po);
    par_en = pe; par_odd = po;
    sync_tick();
    wr(d);
    chk("R6 empty cleared by write", stat_o[0], 1'b0);
    step();
    chk("R4 line still mark on load bit", txd, 1'b1);
    chk("R6 empty set on load", stat_o[0], 1'b1);
    step();
    chk("R4 start bit", txd, 1'b0);
    chk("R8 sclk high in start", sclk, 1'b1);
    bits(d, pe, po);
    step();
    chk("R7 done set after stop", stat_o[1], 1'b1);
    rd_status();
  endtask

  task automatic t_reset();
    chk("R1 txd idle", txd, 1'b1);
    chk("R1 sclk idle", sclk, 1'b1);
    chk("R1 status", stat_o, 2'b01);
    chk("R1 R9 irq low after enable", irq, 1'b0);
  endtask

  task automatic t_first_frame();
    irq_done_sel = 1'b0; par_en = 1'b0; par_odd = 1'b0;
    sync_tick();
    wr(8'hA5);
    chk("R6 empty cleared", stat_o[0], 1'b0);
    chk("R9 irq low before first load", irq, 1'b0);
    step();
    chk("R4 load bit mark", txd, 1'b1);
    chk("R9 irq armed by first load", irq, 1'b1);
    step();
    chk("R4 start bit", txd, 1'b0);
    bits(8'hA5, 1'b0, 1'b0);
    step();
    chk("R7 done set", stat_o[1], 1'b1);
    repeat (12) @(negedge clk);
    chk("R7 done held until read", stat_o[1], 1'b1);
    chk("R2 line idles at mark", txd, 1'b1);
    rd_status();
    chk("R7 done cleared by read", stat_o[1], 1'b0);
  endtask

  task automatic t_parity();
    frame_from_idle(8'h07, 1'b1, 1'b0); // R3 even, three ones
    frame_from_idle(8'h03, 1'b1, 1'b1); // R3 odd, two ones
    frame_from_idle(8'h03, 1'b1, 1'b0); // R3 even, two ones
  endtask

  task automatic t_back_to_back();
    par_en = 1'b0;
    sync_tick();
    wr(8'h3C);
    step();
    step();
    chk("R4 start of first", txd, 1'b0);
    wr(8'hC9);
    chk("R6 empty cleared mid-frame", stat_o[0], 1'b0);
    chk("R9 irq follows empty", irq, 1'b0);
    bits(8'h3C, 1'b0, 1'b0);
    step();
    chk("R5 start follows stop with no gap", txd, 1'b0);
    chk("R6 empty set on reload", stat_o[0], 1'b1);
    chk("R7 done not set while data pending", stat_o[1], 1'b0);
    bits(8'hC9, 1'b0, 1'b0);
    step();
    chk("R7 done after last frame", stat_o[1], 1'b1);
    rd_status();
  endtask

  task automatic t_overwrite();
    sync_tick();
    wr(8'h11);
    wr(8'h6E);
    step();
    step();
    chk("R12 start", txd, 1'b0);
    bits(8'h6E, 1'b0, 1'b0);
    step();
    rd_status();
  endtask

  task automatic t_done_irq();
    irq_done_sel = 1'b1;
    @(negedge clk);
    chk("R10 irq low with done clear", irq, 1'b0);
    sync_tick();
    wr(8'h81);
    step(); step();
    bits(8'h81, 1'b0, 1'b0);
    chk("R10 irq low before stop ends", irq, 1'b0);
    step();
    chk("R10 irq follows done", irq, 1'b1);
    rd_status();
    chk("R10 irq cleared by read", irq, 1'b0);
    irq_done_sel = 1'b0;
  endtask

  task automatic t_disable();
    sync_tick();
    wr(8'h00);
    step(); step(); step();
    chk("R11 pre: data bit 0 low", txd, 1'b0);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk("R11 line mark when off", txd, 1'b1);
    chk("R11 sclk high when off", sclk, 1'b1);
    chk("R11 flags clear when off", stat_o, 2'b00);
    chk("R11 irq low when off", irq, 1'b0);
    wr(8'h55);
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    chk("R11 write ignored while off", stat_o, 2'b01);
    chk("R11 R9 armed state cleared", irq, 1'b0);
    step(); step(); step();
    chk("R11 nothing sent", txd, 1'b1);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; ended = 1'b0;
    rst_n = 1'b0; en = 1'b0; tick_on = 1'b1; par_en = 1'b0; par_odd = 1'b0;
    irq_done_sel = 1'b0; wr_en = 1'b0; wr_data = '0; stat_rd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_frame();
    t_parity();
    t_back_to_back();
    t_overwrite();
    t_done_irq();
    t_disable();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule